// File: doc/BRIEF.md
# Paged Read Port for a One-Time-Programmable Memory

This block is a cycle-based behavioural model of the read side of a one-time-programmable memory. The memory holds 16-bit words. The port can present them as whole words on two 8-bit lanes, or as single bytes on the lower lane. In byte mode an extra least-significant address input chooses which half of the stored word is returned. Unprogrammed locations read as all ones. A backdoor task on the module clears chosen bits, which models programmed zeros.

Reads are timed by a down-counter. A fresh access takes the full latency. The block keeps a page of 8 words (16 bytes in byte mode) loaded. Once the page is loaded, an access that changes only the in-page bits finishes in the shorter page latency.

An identification mode returns a fixed manufacturer word or device word in place of array data. Both codes have odd parity, with bit 15 as the parity bit. Any other address bit set in this mode is an illegal access: the block returns all ones and raises an error flag.

Top module: `pgrom_rd`

## Requirements
- R1: While reset is applied and afterwards until an access completes, `valid` is 0, `lane_oe` is 2'b00 and `dout` is 0.
- R2: An access that starts with `cs` just raised, with a different `addr[AW-1:3]`, or before the page is loaded asserts `valid` exactly FULL_LAT (default 9) rising edges after the inputs change. It is low on the edge before that.
- R3: Once the page is loaded and `cs` stays high, a change confined to the in-page bits asserts `valid` after PAGE_LAT (default 5) rising edges. The in-page bits are `addr[2:0]` in word mode, and `addr[2:0]` plus `lsb_in` in byte mode.
- R4: With `cs` low, `lane_oe` is 2'b00, `dout` is 0 and `valid` is 0, whatever `oe` is. Raising `cs` again starts a full-latency access.
- R5: With `cs` high and `oe` low, `lane_oe` is 2'b00 and `dout` is 0. Raising `oe` again does not restart a completed access.
- R6: In word mode (`byte_mode`=0), a completed and enabled read drives `lane_oe`=2'b11 and `dout` = the stored word. `lsb_in` has no effect in this mode.
- R7: In byte mode, `lane_oe`=2'b01 and `dout[15:8]`=0. `lsb_in`=1 puts stored bits 15:8 on `dout[7:0]`, and `lsb_in`=0 puts stored bits 7:0 there.
- R8: A location never cleared through the backdoor reads 16'hFFFF.
- R9: In identification mode, `addr`=0 returns 16'h00C2 and `addr`=1 returns 16'hB816. Each has odd parity over all 16 bits.
- R10: In identification mode with any of `addr[AW-1:1]` nonzero, `id_err` is 1 while `cs` is high, and the read returns 16'hFFFF.
- R11: A change of `byte_mode` or `id_mode` while `cs` stays high forces a full-latency access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| lsb_in | input | 1 | Byte select within a word (byte mode only) |
| cs | input | 1 | Chip select, active high |
| oe | input | 1 | Output enable, active high |
| byte_mode | input | 1 | 1 = byte organisation, 0 = word |
| id_mode | input | 1 | 1 = identification readout |
| dout | output | 16 | Read data; zero on lanes not driven |
| lane_oe | output | 2 | Per-lane drive enable: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| valid | output | 1 | Current access has completed |
| id_err | output | 1 | Illegal identification address |

## Verification
The latency state is entirely in the counter and the stored page key. A wrong key or a wrong counter load shows at `valid` as an edge that comes early or late. The bench therefore samples `valid` on the edge before and the edge of its expected rise, which exposes an off-by-one in the first access that follows the fault. A stale page flag would turn a full access into a five-cycle one, and this is caught on the first cross-page or mode-change access. Lane selection faults show at once on `lane_oe` and `dout`, which the bench compares against known programmed words.

// File: rtl/pgrom_rd.sv
module pgrom_rd #(
  parameter int AW = 8,
  parameter int PW = 3,
  parameter int FULL_LAT = 9,
  parameter int PAGE_LAT = 5,
  parameter logic [15:0] MFR_CODE = 16'h00C2,
  parameter logic [15:0] DEV_CODE = 16'hB816
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          lsb_in,
  input  logic          cs,
  input  logic          oe,
  input  logic          byte_mode,
  input  logic          id_mode,
  output logic [15:0]   dout,
  output logic [1:0]    lane_oe,
  output logic          valid,
  output logic          id_err
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(FULL_LAT + 1);
  localparam int UW = AW - PW;

  logic [15:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
  end

  task automatic burn_zeros(input logic [AW-1:0] a, input logic [15:0] zmask);
    mem[a] = mem[a] & ~zmask;
  endtask

  logic [UW-1:0] up_q;
  logic [PW:0]   in_q;
  logic [1:0]    md_q;
  logic [CW-1:0] cnt_q;
  logic          act_q, ld_q;

  wire [UW-1:0] up_now = addr[AW-1:PW];
  wire [PW:0]   in_now = {addr[PW-1:0], byte_mode & lsb_in};
  wire [1:0]    md_now = {byte_mode, id_mode};

  wire same_pg  = act_q && (up_q == up_now) && (md_q == md_now);
  wire in_moved = (in_q != in_now);
  wire pg_rdy   = ld_q || (cnt_q == '0);
  wire go_full  = !same_pg || (in_moved && !pg_rdy);
  wire go_hit   = same_pg && in_moved && pg_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ld_q  <= 1'b0;
      cnt_q <= '0;
      up_q  <= '0;
      in_q  <= '0;
      md_q  <= '0;
    end else if (!cs) begin
      act_q <= 1'b0;
      ld_q  <= 1'b0;
      cnt_q <= '0;
    end else if (go_full) begin
      act_q <= 1'b1;
      ld_q  <= 1'b0;
      up_q  <= up_now;
      in_q  <= in_now;
      md_q  <= md_now;
      cnt_q <= CW'(FULL_LAT - 1);
    end else if (go_hit) begin
      in_q  <= in_now;
      cnt_q <= CW'(PAGE_LAT - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      ld_q <= 1'b1;
    end
  end

  wire id_bad = id_mode && (addr[AW-1:1] != '0);
  wire [15:0] word = !id_mode ? mem[addr] :
                     id_bad   ? 16'hFFFF :
                     addr[0]  ? DEV_CODE : MFR_CODE;
  wire drive = valid && oe;

  assign valid   = cs && same_pg && !in_moved && (cnt_q == '0);
  assign id_err  = cs && id_bad;
  assign lane_oe = {drive && !byte_mode, drive};
  assign dout    = !drive   ? 16'h0000 :
                   byte_mode ? {8'h00, lsb_in ? word[15:8] : word[7:0]} : word;

  // R4
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (lane_oe == 2'b00) && !valid && (dout == 16'h0000));
  // R5
  out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !oe) |-> (lane_oe == 2'b00) && (dout == 16'h0000));
  // R7
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> !lane_oe[1] && (dout[15:8] == 8'h00));
  // R2
  full_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs) |=> !valid);
  // R9
  id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe == 2'b11 && id_mode && !id_err) |-> (^dout));
  // R10
  id_err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_err && lane_oe == 2'b11) |-> (dout == 16'hFFFF));
endmodule

// File: tb/sim_pgrom_rd.sv
module sim_pgrom_rd;
  localparam int CLK_P = 10;
  localparam int FL = 9;
  localparam int PL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic lsb_in = 0, cs = 0, oe = 0, byte_mode = 0, id_mode = 0;
  logic [15:0] dout;
  logic [1:0] lane_oe;
  logic valid, id_err;
  int checks = 0, errors = 0;

  pgrom_rd u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .lsb_in(lsb_in), .cs(cs), .oe(oe),
               .byte_mode(byte_mode), .id_mode(id_mode), .dout(dout), .lane_oe(lane_oe),
               .valid(valid), .id_err(id_err));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lat_chk(input int n, input string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " early"}, 32'(valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " ready"}, 32'(valid), 1);
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(valid), 0);
    chk("R1 lane_oe", 32'(lane_oe), 0);
    chk("R1 dout", 32'(dout), 0);
  endtask

  task automatic t_word;
    cs = 1; oe = 1; addr = 8'h10;
    lat_chk(FL, "R2 first access");
    chk("R6 data", 32'(dout), 32'h1234);
    chk("R6 lanes", 32'(lane_oe), 2'b11);
    lsb_in = 1; #1;
    chk("R6 lsb ignored valid", 32'(valid), 1);
    chk("R6 lsb ignored data", 32'(dout), 32'h1234);
    @(negedge clk); lsb_in = 0;
    addr = 8'h13;
    lat_chk(PL, "R3 word page hit");
    chk("R3 data", 32'(dout), 32'hBEEF);
    addr = 8'h28;
    lat_chk(FL, "R2 new page");
    chk("R8 blank", 32'(dout), 32'hFFFF);
  endtask

  task automatic t_enables;
    @(negedge clk); oe = 0; #1;
    chk("R5 lanes off", 32'(lane_oe), 0);
    chk("R5 dout zero", 32'(dout), 0);
    @(negedge clk); oe = 1; #1;
    chk("R5 no restart", 32'(valid), 1);
    chk("R5 data back", 32'(dout), 32'hFFFF);
    @(negedge clk); cs = 0; oe = 1; #1;
    chk("R4 lanes off", 32'(lane_oe), 0);
    chk("R4 valid low", 32'(valid), 0);
    @(posedge clk); @(negedge clk);
    cs = 1;
    lat_chk(FL, "R4 reselect full");
  endtask

  task automatic t_byte;
    @(negedge clk); byte_mode = 1; addr = 8'h10; lsb_in = 0;
    lat_chk(FL, "R11 byte switch");
    chk("R7 low byte", 32'(dout), 32'h0034);
    chk("R7 lanes", 32'(lane_oe), 2'b01);
    lsb_in = 1;
    lat_chk(PL, "R3 lsb hit");
    chk("R7 high byte", 32'(dout), 32'h0012);
    addr = 8'h13;
    lat_chk(PL, "R3 byte page hit");
    chk("R7 high byte 2", 32'(dout), 32'h00BE);
  endtask

  task automatic t_ident;
    @(negedge clk); byte_mode = 0; lsb_in = 0; id_mode = 1; addr = 8'h00;
    lat_chk(FL, "R11 id switch");
    chk("R9 maker", 32'(dout), 32'h00C2);
    chk("R9 maker parity", 32'(^dout), 1);
    addr = 8'h01;
    lat_chk(PL, "R9 id hit");
    chk("R9 device", 32'(dout), 32'hB816);
    chk("R9 device parity", 32'(^dout), 1);
    addr = 8'h04; #1;
    chk("R10 flag", 32'(id_err), 1);
    @(negedge clk);
    lat_chk(PL - 1, "R10 hit");
    chk("R10 data", 32'(dout), 32'hFFFF);
    @(negedge clk); id_mode = 0; addr = 8'h10;
    lat_chk(FL, "R11 id exit");
    chk("R10 flag clear", 32'(id_err), 0);
    chk("R6 data again", 32'(dout), 32'h1234);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    u0.burn_zeros(8'h10, ~16'h1234);
    u0.burn_zeros(8'h13, ~16'hBEEF);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_word;
    t_enables;
    t_byte;
    t_ident;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule